// File: doc/BRIEF.md
# Legacy IDE PIO Cycle Timer

This block connects a simple single-request host I/O bus to a parallel ATA drive cable. It watches host accesses, claims those that fall in the command block or the control port of one legacy IDE channel, and runs one read or write strobe cycle on the cable for each claimed access. The channel, the address window, and the timing used for each of the two drives all come from a 16-bit configuration word. The configuration word is a plain input, held by whatever register file owns it.

Each drive has its own 4-bit control nibble. The data port can use one shared fast timing set, which has a programmable IORDY sample point and recovery time. A drive whose fast-bank bit is clear always gets the slow compatible timing. Every other register always gets the slow compatible timing. When IORDY sampling is on for the selected drive, the strobe stretches until the drive reports ready. A wait limit keeps a silent drive from hanging the bus, and a sticky flag records when that limit was hit. The block also routes the drive interrupt to the legacy line of the selected channel. It keeps its own copy of the drive-select bit, taken from host writes to the device/head register.

Top module: `ide_pio_timer`

## Requirements
- R1: While configuration bit 15 is 0, `host_claim` stays low for every address, and no chip select, strobe or `host_done` appears.
- R2: Configuration bit 14 picks the channel. With 0, the command block is 0x1F0..0x1F7 and the control port is 0x3F6. With 1, they are 0x170..0x177 and 0x376. All other addresses are not claimed. A command-block cycle pulls `ata_cs0_n` low with `ata_da` equal to address bits [2:0]. A control-port cycle pulls `ata_cs1_n` low with `ata_da` equal to 6.
- R3: `irq14` follows `ata_intrq` when the block is enabled with bit 14 at 0. `irq15` follows `ata_intrq` when the block is enabled with bit 14 at 1. Otherwise both stay low.
- R4: Drive 0's nibble is configuration bits [3:0] and drive 1's nibble is bits [7:4]. In a nibble, bit 0 puts the drive on the fast bank and bit 1 enables IORDY sampling. Bit 2 (prefetch) is stored only and has no effect on any cycle.
- R5: The selected drive is bit 4 of the most recent claimed write to command-block offset 6. That write runs under the drive that was selected before it. After reset, drive 0 is selected.
- R6: A data-port (offset 0) access to a drive on the fast bank uses 1 setup clock. Its strobe lasts 5 minus the code in bits [13:12] clocks, and its recovery lasts 4 minus the code in bits [9:8] clocks.
- R7: Every other claimed access uses 3 setup clocks, a 12-clock strobe and 5 recovery clocks, whatever the shared fields hold.
- R8: With IORDY sampling on for the selected drive, the strobe stays active while IORDY is low at the end of its nominal width. It is released on the clock edge where IORDY is seen high. With sampling off, IORDY has no effect.
- R9: If IORDY is still low after WAIT_LIMIT extra strobe clocks, the strobe is released anyway and `timeout_flag` is set. The flag stays set until reset.
- R10: `host_done` is high for exactly one clock, right after the last recovery clock. Read data is captured from `ata_dd_in` on the edge that releases the strobe and is held on `host_rdata`. A write drives `host_wdata` on `ata_dd_out` with `ata_dd_oe` high for the whole cycle. Only one strobe is ever active at a time.
- R11: After reset, no chip select, strobe, `ata_dd_oe`, `host_done` or `timeout_flag` is active.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_word | input | 16 | Channel, drive nibble and fast timing configuration |
| host_req | input | 1 | One-clock access request |
| host_wr | input | 1 | 1 = write, 0 = read |
| host_addr | input | ADDR_W | I/O address |
| host_wdata | input | DATA_W | Write data |
| host_claim | output | 1 | Request decodes to this channel |
| host_done | output | 1 | One-clock completion pulse |
| host_rdata | output | DATA_W | Last captured read data |
| ata_cs0_n | output | 1 | Command block select, active low |
| ata_cs1_n | output | 1 | Control block select, active low |
| ata_da | output | 3 | Register address on the cable |
| ata_dior_n | output | 1 | Read strobe, active low |
| ata_diow_n | output | 1 | Write strobe, active low |
| ata_dd_out | output | DATA_W | Data driven to the cable |
| ata_dd_oe | output | 1 | Output enable for ata_dd_out |
| ata_dd_in | input | DATA_W | Data from the cable |
| ata_iordy | input | 1 | Drive ready |
| ata_intrq | input | 1 | Drive interrupt request |
| irq14 | output | 1 | Primary channel interrupt line |
| irq15 | output | 1 | Secondary channel interrupt line |
| timeout_flag | output | 1 | Sticky IORDY wait timeout |

## Verification
The bench builds the block with WAIT_LIMIT set to 16 and keeps every other parameter at its default. At 16, a drive that never raises IORDY hits the timeout within a few dozen clocks, so both the release on timeout and the sticky flag are checked many times within the run. The default widths and compatible timing keep the real legacy address windows and the 3/12/5 cycle, so the address decode and phase lengths the bench measures are the production ones.

// File: rtl/ide_pio_pkg.sv
package ide_pio_pkg;
  localparam int CFG_W  = 16;
  localparam int TCNT_W = 8;

  localparam int BIT_ENABLE    = 15;
  localparam int BIT_SECONDARY = 14;
  localparam int SAMPLE_LSB    = 12;
  localparam int RECOV_LSB     = 8;

  localparam logic [2:0] DATA_OFF    = 3'd0;
  localparam logic [2:0] DEVHEAD_OFF = 3'd6;
  localparam logic [2:0] CTL_DA      = 3'd6;

  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_SETUP  = 2'd1,
    PH_STROBE = 2'd2,
    PH_RECOV  = 2'd3
  } pio_phase_e;

  // per-drive nibble, bit 3 down to bit 0
  typedef struct packed {
    logic rsvd;
    logic prefetch;
    logic iordy_en;
    logic fast;
  } drv_ctl_t;

  typedef struct packed {
    logic [TCNT_W-1:0] setup;
    logic [TCNT_W-1:0] strobe;
    logic [TCNT_W-1:0] recov;
  } cyc_timing_t;

  function automatic logic [TCNT_W-1:0] sample_clocks(input logic [1:0] code);
    return TCNT_W'(5) - TCNT_W'(code);
  endfunction

  function automatic logic [TCNT_W-1:0] recovery_clocks(input logic [1:0] code);
    return TCNT_W'(4) - TCNT_W'(code);
  endfunction

  function automatic drv_ctl_t drive_nibble(input logic [CFG_W-1:0] cfg, input logic drv);
    return drv ? drv_ctl_t'(cfg[7:4]) : drv_ctl_t'(cfg[3:0]);
  endfunction
endpackage

// File: rtl/ide_addr_decode.sv
module ide_addr_decode #(
  parameter int ADDR_W = 16
) (
  input  logic              enable,
  input  logic              secondary,
  input  logic [ADDR_W-1:0] addr,
  input  logic              intrq,
  output logic              hit_cmd,
  output logic              hit_ctl,
  output logic [1:0]        irq_lines
);
  logic [1:0] cmd_v;
  logic [1:0] ctl_v;

  for (genvar ch = 0; ch < 2; ch++) begin : g_chan
    localparam logic [ADDR_W-1:0] CMD_BASE = (ch == 0) ? ADDR_W'(16'h01F0) : ADDR_W'(16'h0170);
    localparam logic [ADDR_W-1:0] CTL_PORT = (ch == 0) ? ADDR_W'(16'h03F6) : ADDR_W'(16'h0376);
    logic chan_on;
    assign chan_on      = enable && (secondary == (ch == 1));
    assign cmd_v[ch]    = chan_on && (addr[ADDR_W-1:3] == CMD_BASE[ADDR_W-1:3]);
    assign ctl_v[ch]    = chan_on && (addr == CTL_PORT);
    assign irq_lines[ch] = chan_on && intrq;
  end

  assign hit_cmd = |cmd_v;
  assign hit_ctl = |ctl_v;
endmodule

// File: rtl/ide_drive_ctl.sv
module ide_drive_ctl
  import ide_pio_pkg::*;
#(
  parameter int FAST_SETUP    = 1,
  parameter int COMPAT_SETUP  = 3,
  parameter int COMPAT_STROBE = 12,
  parameter int COMPAT_RECOV  = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CFG_W-1:0] cfg_word,
  input  logic             sel_wr_en,
  input  logic             sel_wr_bit,
  input  logic             data_port,
  output logic             cur_drive,
  output cyc_timing_t      timing,
  output logic             iordy_en
);
  logic     drive_q;
  drv_ctl_t ctl;
  logic     use_fast;
  logic     cfg_unused;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         drive_q <= 1'b0;
    else if (sel_wr_en) drive_q <= sel_wr_bit;
  end

  assign cur_drive = drive_q;
  assign ctl       = drive_nibble(cfg_word, drive_q);
  assign use_fast  = data_port && ctl.fast;
  assign iordy_en  = ctl.iordy_en;

  always_comb begin
    if (use_fast) begin
      timing.setup  = TCNT_W'(FAST_SETUP);
      timing.strobe = sample_clocks(cfg_word[SAMPLE_LSB +: 2]);
      timing.recov  = recovery_clocks(cfg_word[RECOV_LSB +: 2]);
    end else begin
      timing.setup  = TCNT_W'(COMPAT_SETUP);
      timing.strobe = TCNT_W'(COMPAT_STROBE);
      timing.recov  = TCNT_W'(COMPAT_RECOV);
    end
  end

  // prefetch is held in the configuration word only
  assign cfg_unused = ^{cfg_word[15:14], cfg_word[11:10], ctl.prefetch, ctl.rsvd};
endmodule

// File: rtl/ide_strobe_fsm.sv
module ide_strobe_fsm
  import ide_pio_pkg::*;
#(
  parameter int DATA_W     = 16,
  parameter int WAIT_LIMIT = 256
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              start_wr,
  input  logic              start_iordy_en,
  input  cyc_timing_t       start_timing,
  input  logic              iordy,
  input  logic [DATA_W-1:0] dd_in,
  output pio_phase_e        phase,
  output logic              wr_active,
  output logic [DATA_W-1:0] rdata,
  output logic              done,
  output logic              timeout_flag,
  output logic              hold_evt,
  output logic              release_evt
);
  localparam int WAIT_W = $clog2(WAIT_LIMIT + 1);

  pio_phase_e        phase_q;
  logic [TCNT_W-1:0] cnt_q, str_q, rec_q;
  logic [WAIT_W-1:0] wait_q;
  logic              ien_q, wr_q, done_q, tmo_q;
  logic [DATA_W-1:0] rdata_q;
  logic              at_sample, ready_low, wait_full;

  assign at_sample   = (phase_q == PH_STROBE) && (cnt_q == '0);
  assign ready_low   = ien_q && !iordy;
  assign wait_full   = (wait_q == WAIT_W'(WAIT_LIMIT));
  assign hold_evt    = at_sample && ready_low && !wait_full;
  assign release_evt = at_sample && !hold_evt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
      str_q   <= '0;
      rec_q   <= '0;
      wait_q  <= '0;
      ien_q   <= 1'b0;
      wr_q    <= 1'b0;
      done_q  <= 1'b0;
      tmo_q   <= 1'b0;
      rdata_q <= '0;
    end else begin
      done_q <= 1'b0;
      unique case (phase_q)
        PH_IDLE: if (start) begin
          phase_q <= PH_SETUP;
          cnt_q   <= start_timing.setup - TCNT_W'(1);
          str_q   <= start_timing.strobe;
          rec_q   <= start_timing.recov;
          wr_q    <= start_wr;
          ien_q   <= start_iordy_en;
        end
        PH_SETUP: begin
          if (cnt_q == '0) begin
            phase_q <= PH_STROBE;
            cnt_q   <= str_q - TCNT_W'(1);
            wait_q  <= '0;
          end else begin
            cnt_q <= cnt_q - TCNT_W'(1);
          end
        end
        PH_STROBE: begin
          if (cnt_q != '0) begin
            cnt_q <= cnt_q - TCNT_W'(1);
          end else if (hold_evt) begin
            wait_q <= wait_q + WAIT_W'(1);
          end else begin
            phase_q <= PH_RECOV;
            cnt_q   <= rec_q - TCNT_W'(1);
            if (!wr_q) rdata_q <= dd_in;
            if (ready_low) tmo_q <= 1'b1;
          end
        end
        PH_RECOV: begin
          if (cnt_q == '0) begin
            phase_q <= PH_IDLE;
            done_q  <= 1'b1;
          end else begin
            cnt_q <= cnt_q - TCNT_W'(1);
          end
        end
        default: phase_q <= PH_IDLE;
      endcase
    end
  end

  assign phase        = phase_q;
  assign wr_active    = wr_q;
  assign rdata        = rdata_q;
  assign done         = done_q;
  assign timeout_flag = tmo_q;
endmodule

// File: rtl/ide_pio_timer.sv
module ide_pio_timer
  import ide_pio_pkg::*;
#(
  parameter int ADDR_W        = 16,
  parameter int DATA_W        = 16,
  parameter int WAIT_LIMIT    = 256,
  parameter int FAST_SETUP    = 1,
  parameter int COMPAT_SETUP  = 3,
  parameter int COMPAT_STROBE = 12,
  parameter int COMPAT_RECOV  = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [15:0]       cfg_word,
  input  logic              host_req,
  input  logic              host_wr,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [DATA_W-1:0] host_wdata,
  output logic              host_claim,
  output logic              host_done,
  output logic [DATA_W-1:0] host_rdata,
  output logic              ata_cs0_n,
  output logic              ata_cs1_n,
  output logic [2:0]        ata_da,
  output logic              ata_dior_n,
  output logic              ata_diow_n,
  output logic [DATA_W-1:0] ata_dd_out,
  output logic              ata_dd_oe,
  input  logic [DATA_W-1:0] ata_dd_in,
  input  logic              ata_iordy,
  input  logic              ata_intrq,
  output logic              irq14,
  output logic              irq15,
  output logic              timeout_flag
);
  logic              hit_cmd, hit_ctl;
  logic [1:0]        irq_lines;
  logic              idle, busy, start, data_port, sel_wr_en;
  logic              cur_drive, iordy_en, wr_active;
  cyc_timing_t       timing;
  pio_phase_e        phase;
  logic              hold_evt, release_evt;
  logic              cyc_ctl_q;
  logic [2:0]        da_q;
  logic [DATA_W-1:0] wdata_q;
  logic              strobe_on;

  ide_addr_decode #(.ADDR_W(ADDR_W)) u_dec (
    .enable    (cfg_word[BIT_ENABLE]),
    .secondary (cfg_word[BIT_SECONDARY]),
    .addr      (host_addr),
    .intrq     (ata_intrq),
    .hit_cmd   (hit_cmd),
    .hit_ctl   (hit_ctl),
    .irq_lines (irq_lines)
  );

  assign host_claim = host_req && (hit_cmd || hit_ctl);
  assign idle       = (phase == PH_IDLE);
  assign busy       = !idle;
  assign start      = host_claim && idle;
  assign data_port  = hit_cmd && (host_addr[2:0] == DATA_OFF);
  assign sel_wr_en  = start && host_wr && hit_cmd && (host_addr[2:0] == DEVHEAD_OFF);

  ide_drive_ctl #(
    .FAST_SETUP    (FAST_SETUP),
    .COMPAT_SETUP  (COMPAT_SETUP),
    .COMPAT_STROBE (COMPAT_STROBE),
    .COMPAT_RECOV  (COMPAT_RECOV)
  ) u_drv (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_word   (cfg_word),
    .sel_wr_en  (sel_wr_en),
    .sel_wr_bit (host_wdata[4]),
    .data_port  (data_port),
    .cur_drive  (cur_drive),
    .timing     (timing),
    .iordy_en   (iordy_en)
  );

  ide_strobe_fsm #(.DATA_W(DATA_W), .WAIT_LIMIT(WAIT_LIMIT)) u_fsm (
    .clk            (clk),
    .rst_n          (rst_n),
    .start          (start),
    .start_wr       (host_wr),
    .start_iordy_en (iordy_en),
    .start_timing   (timing),
    .iordy          (ata_iordy),
    .dd_in          (ata_dd_in),
    .phase          (phase),
    .wr_active      (wr_active),
    .rdata          (host_rdata),
    .done           (host_done),
    .timeout_flag   (timeout_flag),
    .hold_evt       (hold_evt),
    .release_evt    (release_evt)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cyc_ctl_q <= 1'b0;
      da_q      <= '0;
      wdata_q   <= '0;
    end else if (start) begin
      cyc_ctl_q <= hit_ctl;
      da_q      <= hit_ctl ? CTL_DA : host_addr[2:0];
      wdata_q   <= host_wdata;
    end
  end

  assign strobe_on  = (phase == PH_STROBE);
  assign ata_cs0_n  = !(busy && !cyc_ctl_q);
  assign ata_cs1_n  = !(busy && cyc_ctl_q);
  assign ata_da     = busy ? da_q : 3'd0;
  assign ata_dior_n = !(strobe_on && !wr_active);
  assign ata_diow_n = !(strobe_on && wr_active);
  assign ata_dd_out = wdata_q;
  assign ata_dd_oe  = busy && wr_active;
  assign irq14      = irq_lines[0];
  assign irq15      = irq_lines[1];

  logic drive_unused;
  assign drive_unused = cur_drive;
endmodule

// File: rtl/ide_pio_timer_sva.sv
module ide_pio_timer_sva #(
  parameter int WAIT_LIMIT    = 256,
  parameter int COMPAT_STROBE = 12
) (
  input logic        clk,
  input logic        rst_n,
  input logic [15:0] cfg_word,
  input logic        host_req,
  input logic        host_claim,
  input logic        host_done,
  input logic        ata_cs0_n,
  input logic        ata_cs1_n,
  input logic        ata_dior_n,
  input logic        ata_diow_n,
  input logic        irq14,
  input logic        irq15,
  input logic        timeout_flag,
  input logic        hold_evt,
  input logic        release_evt
);
  localparam int MAX_NOM = (COMPAT_STROBE > 5) ? COMPAT_STROBE : 5;
  localparam int MAX_RUN = MAX_NOM + WAIT_LIMIT;
  localparam int RUN_W   = $clog2(MAX_RUN + 2);

  logic strobe;
  logic [RUN_W-1:0] run_q;
  assign strobe = !ata_dior_n || !ata_diow_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      run_q <= '0;
    else if (strobe) run_q <= run_q + RUN_W'(1);
    else             run_q <= '0;
  end

  assert_disabled_no_claim_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (host_req && !cfg_word[15]) |-> !host_claim);

  assert_single_select_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ata_cs0_n || ata_cs1_n);

  assert_strobe_in_select_R2: assert property (@(posedge clk) disable iff (!rst_n)
    strobe |-> (!ata_cs0_n || !ata_cs1_n));

  assert_irq14_primary_R3: assert property (@(posedge clk) disable iff (!rst_n)
    irq14 |-> (cfg_word[15] && !cfg_word[14]));

  assert_irq15_secondary_R3: assert property (@(posedge clk) disable iff (!rst_n)
    irq15 |-> (cfg_word[15] && cfg_word[14]));

  assert_hold_keeps_strobe_R8: assert property (@(posedge clk) disable iff (!rst_n)
    hold_evt |=> strobe);

  assert_release_drops_strobe_R8: assert property (@(posedge clk) disable iff (!rst_n)
    release_evt |=> !strobe);

  assert_timeout_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    timeout_flag |=> timeout_flag);

  assert_wait_bounded_R9: assert property (@(posedge clk) disable iff (!rst_n)
    run_q <= RUN_W'(MAX_RUN));

  assert_one_strobe_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({!ata_dior_n, !ata_diow_n}));

  assert_done_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
    host_done |=> !host_done);
endmodule

bind ide_pio_timer ide_pio_timer_sva #(
  .WAIT_LIMIT    (WAIT_LIMIT),
  .COMPAT_STROBE (COMPAT_STROBE)
) u_sva (
  .clk          (clk),
  .rst_n        (rst_n),
  .cfg_word     (cfg_word),
  .host_req     (host_req),
  .host_claim   (host_claim),
  .host_done    (host_done),
  .ata_cs0_n    (ata_cs0_n),
  .ata_cs1_n    (ata_cs1_n),
  .ata_dior_n   (ata_dior_n),
  .ata_diow_n   (ata_diow_n),
  .irq14        (irq14),
  .irq15        (irq15),
  .timeout_flag (timeout_flag),
  .hold_evt     (hold_evt),
  .release_evt  (release_evt)
);

// File: tb/tb_ide_pio_timer.sv
module tb_ide_pio_timer;
  localparam int WL = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] cfg_word = 16'h0000;
  logic        host_req = 1'b0;
  logic        host_wr = 1'b0;
  logic [15:0] host_addr = 16'h0000;
  logic [15:0] host_wdata = 16'h0000;
  logic        host_claim, host_done;
  logic [15:0] host_rdata;
  logic        ata_cs0_n, ata_cs1_n, ata_dior_n, ata_diow_n, ata_dd_oe;
  logic [2:0]  ata_da;
  logic [15:0] ata_dd_out;
  logic [15:0] ata_dd_in = 16'h0000;
  logic        ata_iordy = 1'b1;
  logic        ata_intrq = 1'b0;
  logic        irq14, irq15, timeout_flag;

  int  checks = 0;
  int  errors = 0;
  bit  drv_m = 1'b0;
  bit  tmo_m = 1'b0;

  always #5 clk = ~clk;

  ide_pio_timer #(.WAIT_LIMIT(WL)) dut (
    .clk(clk), .rst_n(rst_n), .cfg_word(cfg_word),
    .host_req(host_req), .host_wr(host_wr), .host_addr(host_addr), .host_wdata(host_wdata),
    .host_claim(host_claim), .host_done(host_done), .host_rdata(host_rdata),
    .ata_cs0_n(ata_cs0_n), .ata_cs1_n(ata_cs1_n), .ata_da(ata_da),
    .ata_dior_n(ata_dior_n), .ata_diow_n(ata_diow_n),
    .ata_dd_out(ata_dd_out), .ata_dd_oe(ata_dd_oe), .ata_dd_in(ata_dd_in),
    .ata_iordy(ata_iordy), .ata_intrq(ata_intrq),
    .irq14(irq14), .irq15(irq15), .timeout_flag(timeout_flag)
  );

  task automatic chk(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // channel windows restated from R2
  function automatic void exp_decode(input logic [15:0] cfg, input logic [15:0] addr,
                                     output bit is_cmd, output bit is_ctl);
    logic [15:0] lo, port;
    lo   = cfg[14] ? 16'h0170 : 16'h01F0;
    port = cfg[14] ? 16'h0376 : 16'h03F6;
    is_cmd = cfg[15] && (addr >= lo) && (addr <= lo + 16'd7);
    is_ctl = cfg[15] && (addr == port);
  endfunction

  // phase lengths restated from R6/R7
  function automatic void exp_phases(input logic [15:0] cfg, input bit drv, input bit data,
                                     output int s, output int a, output int r);
    bit on_fast;
    on_fast = data && (drv ? cfg[4] : cfg[0]);
    if (on_fast) begin
      s = 1;
      a = 2 + (3 - int'(cfg[13:12]));
      r = 1 + (3 - int'(cfg[9:8]));
    end else begin
      s = 3; a = 12; r = 5;
    end
  endfunction

  // iordy_mode: 0 ready throughout, N>0 raised once N strobe clocks seen, -1 never ready
  task automatic access(input logic [15:0] cfg, input logic [15:0] addr, input bit wr,
                        input logic [15:0] wd, input logic [15:0] din, input int iordy_mode,
                        input string tag);
    bit is_cmd, is_ctl, claimed, ien, seen, got_done;
    int es, ea, er, s, a, r, n, limit, activity;
    exp_decode(cfg, addr, is_cmd, is_ctl);
    claimed = is_cmd || is_ctl;
    exp_phases(cfg, drv_m, is_cmd && (addr[2:0] == 3'd0), es, ea, er);
    ien = drv_m ? cfg[5] : cfg[1];
    if (ien && iordy_mode < 0) ea = ea + WL;
    else if (ien && iordy_mode > ea) ea = iordy_mode;

    @(negedge clk);
    cfg_word = cfg; host_addr = addr; host_wr = wr; host_wdata = wd;
    ata_dd_in = din; ata_iordy = (iordy_mode == 0); host_req = 1'b1;
    #1;
    chk({tag, " R2 claim"}, host_claim, claimed);
    @(negedge clk);
    host_req = 1'b0;
    s = 0; a = 0; r = 0; n = 0; seen = 0; got_done = 0; activity = 0;
    limit = claimed ? 600 : 20;
    while (n < limit) begin
      if (host_done) begin
        got_done = 1;
        break;
      end
      if (!ata_dior_n || !ata_diow_n) begin
        a++; seen = 1; activity++;
        if (a == 1 && claimed) begin
          chk({tag, " R2 cs0"}, ata_cs0_n, is_ctl);
          chk({tag, " R2 cs1"}, ata_cs1_n, !is_ctl);
          chk({tag, " R2 da"}, ata_da, is_ctl ? 3'd6 : addr[2:0]);
          chk({tag, " R10 strobe dir"}, ata_diow_n, !wr);
          chk({tag, " R10 oe"}, ata_dd_oe, wr);
          if (wr) chk({tag, " R10 wdata"}, ata_dd_out, wd);
        end
        if (iordy_mode > 0 && a == iordy_mode) ata_iordy = 1'b1;
      end else if (!ata_cs0_n || !ata_cs1_n) begin
        activity++;
        if (seen) r++; else s++;
      end
      n++;
      @(negedge clk);
    end
    if (claimed) begin
      chk({tag, " R10 done"}, got_done, 1);
      chk({tag, " R6/R7 setup"}, s, es);
      chk({tag, " R6/R7/R8 strobe"}, a, ea);
      chk({tag, " R6/R7 recovery"}, r, er);
      if (!wr) chk({tag, " R10 rdata"}, host_rdata, din);
      @(negedge clk);
      chk({tag, " R10 done width"}, host_done, 0);
      if (ien && iordy_mode < 0) tmo_m = 1'b1;
      chk({tag, " R9 timeout flag"}, timeout_flag, tmo_m);
      if (wr && is_cmd && addr[2:0] == 3'd6) drv_m = wd[4];
    end else begin
      chk({tag, " R1/R2 no activity"}, activity + int'(got_done), 0);
    end
    ata_iordy = 1'b1;
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : main
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    // R11 reset state
    chk("R11 cs0", ata_cs0_n, 1);
    chk("R11 cs1", ata_cs1_n, 1);
    chk("R11 strobes", {ata_dior_n, ata_diow_n}, 2'b11);
    chk("R11 oe", ata_dd_oe, 0);
    chk("R11 done", host_done, 0);
    chk("R11 timeout", timeout_flag, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 disabled
    access(16'h3000, 16'h01F0, 0, 16'h0, 16'h1234, 0, "R1 disabled cmd");
    access(16'h4000, 16'h0376, 1, 16'h55, 16'h0, 0, "R1 disabled ctl");
    // R2 primary/secondary windows, R7 compatible timing
    access(16'h8000, 16'h01F7, 0, 16'h0, 16'hBEEF, 0, "R2 pri status");
    access(16'h8000, 16'h0177, 0, 16'h0, 16'hBEEF, 0, "R2 pri miss");
    access(16'hC000, 16'h0376, 1, 16'h00A5, 16'h0, 0, "R2 sec ctl");
    access(16'hC000, 16'h03F6, 1, 16'h00A5, 16'h0, 0, "R2 sec miss");
    access(16'hC000, 16'h01F8, 0, 16'h0, 16'h0, 0, "R2 past window");

    // R3 interrupt routing
    ata_intrq = 1'b1;
    cfg_word = 16'h8000; #1;
    chk("R3 primary irq14", irq14, 1); chk("R3 primary irq15", irq15, 0);
    cfg_word = 16'hC000; #1;
    chk("R3 secondary irq14", irq14, 0); chk("R3 secondary irq15", irq15, 1);
    cfg_word = 16'h4000; #1;
    chk("R3 disabled irqs", {irq14, irq15}, 2'b00);
    ata_intrq = 1'b0; #1;
    cfg_word = 16'hC000; #1;
    chk("R3 no request", {irq14, irq15}, 2'b00);

    // R6 fast timing on drive 0, codes 2 and 1
    access(16'hA101, 16'h01F0, 0, 16'h0, 16'hC0DE, 0, "R6 fast drive0");
    access(16'hB301, 16'h01F0, 1, 16'h7777, 16'h0, 0, "R6 fast min");
    // R7 fast bank bit clear, shared fields set
    access(16'hB310, 16'h01F0, 0, 16'h0, 16'h1111, 0, "R7 drive0 slow");
    access(16'hB311, 16'h01F1, 0, 16'h0, 16'h2222, 0, "R7 non-data reg");
    // R4 prefetch only: no effect
    access(16'hB304, 16'h01F0, 0, 16'h0, 16'h3333, 0, "R4 prefetch only");
    // R5 select drive 1, then its nibble applies
    access(16'hB310, 16'h01F6, 1, 16'h00B0, 16'h0, 0, "R5 select drive1");
    access(16'hB310, 16'h01F0, 0, 16'h0, 16'h4444, 0, "R5 drive1 fast");
    access(16'hB301, 16'h01F0, 0, 16'h0, 16'h4545, 0, "R5 drive1 slow");
    access(16'hB310, 16'h01F6, 1, 16'h00A0, 16'h0, 0, "R5 select drive0");
    // R8 IORDY wait and ignore
    access(16'h8003, 16'h01F0, 0, 16'h0, 16'h5555, 9, "R8 wait fast");
    access(16'h8002, 16'h01F7, 0, 16'h0, 16'h6666, 20, "R8 wait compat");
    access(16'h8001, 16'h01F0, 0, 16'h0, 16'h6767, 9, "R8 ignored");
    // R9 timeout and stickiness
    access(16'h8003, 16'h01F0, 1, 16'h9999, 16'h0, -1, "R9 timeout");
    access(16'h8001, 16'h01F0, 0, 16'h0, 16'h7777, 0, "R9 sticky");

    // constrained random mix
    for (int i = 0; i < 300; i++) begin
      logic [15:0] cfg, addr, lo;
      int k, mode;
      cfg = 16'($urandom);
      cfg[15] = (($urandom % 8) != 0);
      lo = cfg[14] ? 16'h0170 : 16'h01F0;
      k = $urandom % 10;
      if (k < 4)      addr = lo;
      else if (k < 7) addr = lo + 16'($urandom % 8);
      else if (k < 9) addr = cfg[14] ? 16'h0376 : 16'h03F6;
      else            addr = (cfg[14] ? 16'h01F0 : 16'h0170) + 16'($urandom % 8);
      k = $urandom % 10;
      mode = (k < 7) ? 0 : (k < 9) ? 1 + int'($urandom % 20) : -1;
      access(cfg, addr, 1'($urandom), 16'($urandom), 16'($urandom), mode, "random");
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule